// File: doc/BRIEF.md
# Audio Automatic Level Control

This block steers the gain of one decimated audio channel so that the envelope of the signal settles near a programmable target. Each valid sample feeds a peak envelope tracker. The tracker jumps up to any larger magnitude and otherwise sinks slowly toward zero. The tracked envelope is compared with the target and with a lower bound 1.5 dB beneath it. A gain controller then lowers the gain (attack), raises it (release) or leaves it alone. It moves the code by one unit at a time, at a pace counted in valid samples. The output gain code is meant to drive a separate gain stage. Applying the gain to the audio and loading the configuration are done elsewhere.

An emergency clamp acts whenever a single sample's magnitude goes past seven eighths of full scale. In that case the gain drops by one on every valid sample, whatever the mode and the programmed attack pace. A limiter mode runs both paces four times faster. While that mode is on, the upward gain limit is frozen at the gain held when the mode was switched on. The minimum gain applies at all times. The present gain code, the controller phase and the tracked envelope are exported.

Top module: `agc_level_ctrl`

## Requirements
- R1: After reset the gain code equals the GAIN_INIT parameter (32 by default), the phase output is 0 (hold) and the envelope output is 0.
- R2: On each valid sample the magnitude is the absolute sample value, and the most negative code maps to 32767. The envelope takes the magnitude if it is larger. Otherwise the envelope loses envelope>>4, and at least 1 while it is non-zero.
- R3: If the new envelope is above the target, the phase becomes attack (code 1). The gain then falls by one every 2^attack_rate valid samples, and never by more than one per sample.
- R4: An attack phase continues while the envelope stays between target_lo = target - target>>3 - target>>5 and the target. From any other phase, that band gives hold (code 0), and the gain does not change there.
- R5: If the new envelope is below target_lo, the phase becomes release (code 2). The gain then rises by one every 2^release_rate valid samples. Release never lowers the gain.
- R6: A sample whose magnitude exceeds 28672 (7/8 of full scale) sets phase code 3 and lowers the gain by one on that same sample. The attack setting and the mode have no effect on this.
- R7: In normal mode the gain never steps above cfg_gain_max. In every mode it never steps below cfg_gain_min.
- R8: In limiter mode the upward limit is the gain held when cfg_limit_mode rose, and cfg_gain_max is ignored.
- R9: In limiter mode both step intervals are divided by 4, with a minimum of one sample.
- R10: Cycles without a valid strobe change neither the gain, the phase nor the envelope, whatever value the sample input carries.
- R11: When the phase changes, the interval count restarts. The first step of a new phase falls on its N-th valid sample, where N is the interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_vld | input | 1 | Sample strobe |
| smp_data | input | SAMPLE_W | Two's complement audio sample |
| cfg_target | input | SAMPLE_W-1 | Target envelope magnitude |
| cfg_gain_max | input | GAIN_W | Upper gain limit in normal mode |
| cfg_gain_min | input | GAIN_W | Lower gain limit in all modes |
| cfg_atk_rate | input | RATE_W | Attack interval exponent |
| cfg_rel_rate | input | RATE_W | Release interval exponent |
| cfg_limit_mode | input | 1 | Limiter mode enable |
| gain_o | output | GAIN_W | Gain code, 0.75 dB per unit |
| state_o | output | 2 | Phase: 0 hold, 1 attack, 2 release, 3 clamp |
| env_o | output | SAMPLE_W-1 | Tracked peak envelope |

## Verification
The stimulus runs in phases. A loud constant tone shows the attack pace. A tone whose envelope swings just under the target separates attack with hysteresis from hold, because the gain keeps falling down to the floor. A quiet tone drives release up to the ceiling. A tone inside the band, reached from release, must leave the gain alone. Near-full-scale samples, including the most negative code, separate the clamp from ordinary attack while the attack pace is set slow. A limiter segment shows that the frozen ceiling wins over a raised cfg_gain_max and that the intervals shrink by four.

// File: rtl/agc_pkg.sv
`timescale 1ns/1ps
package agc_pkg;
   typedef enum logic [1:0] {
      AGC_HOLD    = 2'd0,
      AGC_ATTACK  = 2'd1,
      AGC_RELEASE = 2'd2,
      AGC_CLAMP   = 2'd3
   } agc_state_e;
endpackage

// File: rtl/agc_env_track.sv
`timescale 1ns/1ps
module agc_env_track #(
   parameter int SAMPLE_W    = 16,
   parameter int DECAY_SHIFT = 4
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  vld,
   input  logic [SAMPLE_W-1:0]   data,
   output logic [SAMPLE_W-2:0]   mag_o,
   output logic [SAMPLE_W-2:0]   env_nxt_o,
   output logic [SAMPLE_W-2:0]   env_o
);
   localparam int MAG_W = SAMPLE_W - 1;

   logic [SAMPLE_W-1:0] neg;
   logic [MAG_W-1:0]    drop_raw;
   logic [MAG_W-1:0]    drop;

   // magnitude with saturation of the most negative code
   always_comb begin
      neg = -data;
      if (!data[SAMPLE_W-1])
         mag_o = data[MAG_W-1:0];
      else if (data[MAG_W-1:0] == '0)
         mag_o = '1;
      else
         mag_o = neg[MAG_W-1:0];
   end

   generate
      if (DECAY_SHIFT == 0) begin : g_instant
         assign drop_raw = env_o;
      end else begin : g_shift
         assign drop_raw = env_o >> DECAY_SHIFT;
      end
   endgenerate

   assign drop      = (drop_raw == '0 && env_o != '0) ? MAG_W'(1) : drop_raw;
   assign env_nxt_o = (mag_o > env_o) ? mag_o : (env_o - drop);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   env_o <= '0;
      else if (vld) env_o <= env_nxt_o;
   end
endmodule

// File: rtl/agc_step_timer.sv
`timescale 1ns/1ps
module agc_step_timer
   import agc_pkg::*;
#(
   parameter int RATE_W    = 4,
   parameter int LIM_SHIFT = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              vld,
   input  agc_state_e        state,
   input  agc_state_e        state_nxt,
   input  logic [RATE_W-1:0] atk_code,
   input  logic [RATE_W-1:0] rel_code,
   input  logic              lim_en,
   output logic              step_o
);
   localparam int CNT_W = 1 << RATE_W;

   logic [RATE_W-1:0] code;
   logic [CNT_W-1:0]  base;
   logic [CNT_W-1:0]  scaled;
   logic [CNT_W-1:0]  interval;
   logic [CNT_W-1:0]  cnt;
   logic [CNT_W-1:0]  cnt_eff;
   logic              hit;

   assign code = (state_nxt == AGC_ATTACK) ? atk_code : rel_code;
   assign base = CNT_W'(1) << code;

   generate
      if (LIM_SHIFT == 0) begin : g_no_div
         assign scaled = base;
      end else begin : g_div
         assign scaled = base >> LIM_SHIFT;
      end
   endgenerate

   always_comb begin
      if (state_nxt == AGC_CLAMP)
         interval = CNT_W'(1);
      else if (lim_en)
         interval = (scaled == '0) ? CNT_W'(1) : scaled;
      else
         interval = base;
   end

   assign cnt_eff = (state_nxt == state) ? cnt : '0;
   assign hit     = (cnt_eff == interval - CNT_W'(1));
   assign step_o  = vld && (state_nxt != AGC_HOLD) && hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (vld) begin
         if (state_nxt == AGC_HOLD || step_o) cnt <= '0;
         else                                 cnt <= cnt_eff + CNT_W'(1);
      end
   end
endmodule

// File: rtl/agc_gain_reg.sv
`timescale 1ns/1ps
module agc_gain_reg
   import agc_pkg::*;
#(
   parameter int GAIN_W    = 6,
   parameter int GAIN_INIT = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              vld,
   input  logic              step,
   input  agc_state_e        state_nxt,
   input  logic [GAIN_W-1:0] gmax,
   input  logic [GAIN_W-1:0] gmin,
   input  logic              lim_en,
   output logic [GAIN_W-1:0] gain_o
);
   logic              lim_q;
   logic [GAIN_W-1:0] cap;
   logic [GAIN_W-1:0] ceil_act;
   logic              go_down;
   logic              go_up;

   always_comb begin
      if (!lim_en)     ceil_act = gmax;
      else if (!lim_q) ceil_act = gain_o;
      else             ceil_act = cap;
   end

   assign go_down = (state_nxt == AGC_ATTACK || state_nxt == AGC_CLAMP) && (gain_o > gmin);
   assign go_up   = (state_nxt == AGC_RELEASE) && (gain_o < ceil_act);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gain_o <= GAIN_W'(GAIN_INIT);
         lim_q  <= 1'b0;
         cap    <= GAIN_W'(GAIN_INIT);
      end else begin
         lim_q <= lim_en;
         if (lim_en && !lim_q) cap <= gain_o;
         if (vld && step) begin
            if (go_down)    gain_o <= gain_o - GAIN_W'(1);
            else if (go_up) gain_o <= gain_o + GAIN_W'(1);
         end
      end
   end
endmodule

// File: rtl/agc_level_ctrl.sv
`timescale 1ns/1ps
module agc_level_ctrl
   import agc_pkg::*;
#(
   parameter int SAMPLE_W    = 16,
   parameter int GAIN_W      = 6,
   parameter int GAIN_INIT   = 32,
   parameter int RATE_W      = 4,
   parameter int LIM_SHIFT   = 2,
   parameter int DECAY_SHIFT = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                smp_vld,
   input  logic [SAMPLE_W-1:0] smp_data,
   input  logic [SAMPLE_W-2:0] cfg_target,
   input  logic [GAIN_W-1:0]   cfg_gain_max,
   input  logic [GAIN_W-1:0]   cfg_gain_min,
   input  logic [RATE_W-1:0]   cfg_atk_rate,
   input  logic [RATE_W-1:0]   cfg_rel_rate,
   input  logic                cfg_limit_mode,
   output logic [GAIN_W-1:0]   gain_o,
   output logic [1:0]          state_o,
   output logic [SAMPLE_W-2:0] env_o
);
   localparam int MAG_W = SAMPLE_W - 1;
   localparam logic [MAG_W-1:0] CLAMP_TH = MAG_W'(7 << (SAMPLE_W - 4));

   generate
      if (SAMPLE_W < 8 || SAMPLE_W > 32) begin : g_bad_sw
         $error("SAMPLE_W out of range");
      end
      if (GAIN_W < 2 || GAIN_INIT < 0 || GAIN_INIT >= (1 << GAIN_W)) begin : g_bad_gain
         $error("gain parameters out of range");
      end
      if (RATE_W < 1 || RATE_W > 5) begin : g_bad_rate
         $error("RATE_W out of range");
      end
      if (LIM_SHIFT < 0 || LIM_SHIFT >= (1 << RATE_W)) begin : g_bad_lim
         $error("LIM_SHIFT out of range");
      end
      if (DECAY_SHIFT < 0 || DECAY_SHIFT >= MAG_W) begin : g_bad_dec
         $error("DECAY_SHIFT out of range");
      end
   endgenerate

   logic [MAG_W-1:0] mag;
   logic [MAG_W-1:0] env_nxt;
   logic [MAG_W-1:0] tgt_lo;
   logic             step;
   agc_state_e       state;
   agc_state_e       state_nxt;

   agc_env_track #(.SAMPLE_W(SAMPLE_W), .DECAY_SHIFT(DECAY_SHIFT)) u_env (
      .clk(clk), .rst_n(rst_n), .vld(smp_vld), .data(smp_data),
      .mag_o(mag), .env_nxt_o(env_nxt), .env_o(env_o)
   );

   // lower edge of the hysteresis band, about 1.5 dB under target
   assign tgt_lo = cfg_target - (cfg_target >> 3) - (cfg_target >> 5);

   always_comb begin
      if (mag > CLAMP_TH)                  state_nxt = AGC_CLAMP;
      else if (env_nxt > cfg_target)       state_nxt = AGC_ATTACK;
      else if (env_nxt < tgt_lo)           state_nxt = AGC_RELEASE;
      else if (state == AGC_ATTACK)        state_nxt = AGC_ATTACK;
      else                                 state_nxt = AGC_HOLD;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       state <= AGC_HOLD;
      else if (smp_vld) state <= state_nxt;
   end

   agc_step_timer #(.RATE_W(RATE_W), .LIM_SHIFT(LIM_SHIFT)) u_timer (
      .clk(clk), .rst_n(rst_n), .vld(smp_vld), .state(state), .state_nxt(state_nxt),
      .atk_code(cfg_atk_rate), .rel_code(cfg_rel_rate), .lim_en(cfg_limit_mode),
      .step_o(step)
   );

   agc_gain_reg #(.GAIN_W(GAIN_W), .GAIN_INIT(GAIN_INIT)) u_gain (
      .clk(clk), .rst_n(rst_n), .vld(smp_vld), .step(step), .state_nxt(state_nxt),
      .gmax(cfg_gain_max), .gmin(cfg_gain_min), .lim_en(cfg_limit_mode),
      .gain_o(gain_o)
   );

   assign state_o = state;
endmodule

// File: rtl/agc_level_ctrl_chk.sv
`timescale 1ns/1ps
module agc_level_ctrl_chk #(
   parameter int SAMPLE_W = 16,
   parameter int GAIN_W   = 6
) (
   input logic                clk,
   input logic                rst_n,
   input logic                smp_vld,
   input logic [SAMPLE_W-1:0] smp_data,
   input logic [GAIN_W-1:0]   cfg_gain_max,
   input logic [GAIN_W-1:0]   cfg_gain_min,
   input logic                cfg_limit_mode,
   input logic [GAIN_W-1:0]   gain_o,
   input logic [1:0]          state_o,
   input logic [SAMPLE_W-2:0] env_o
);
   localparam int MAG_W = SAMPLE_W - 1;
   localparam logic [MAG_W-1:0] TH = MAG_W'(7 << (SAMPLE_W - 4));

   logic [SAMPLE_W-1:0] neg_c;
   logic                loud;
   assign neg_c = -smp_data;
   assign loud  = smp_data[SAMPLE_W-1] ? ((neg_c[MAG_W-1:0] > TH) || (smp_data[MAG_W-1:0] == '0))
                                       : (smp_data[MAG_W-1:0] > TH);

   // R7
   gain_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (gain_o < $past(gain_o)) |-> ($past(gain_o) > $past(cfg_gain_min)));

   // R7
   gain_ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (gain_o > $past(gain_o) && !$past(cfg_limit_mode)) |-> ($past(gain_o) < $past(cfg_gain_max)));

   // R10
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !smp_vld |=> ($stable(gain_o) && $stable(env_o) && $stable(state_o)));

   // R3
   single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (gain_o == $past(gain_o)) || (gain_o == $past(gain_o) + GAIN_W'(1)) ||
      (gain_o == $past(gain_o) - GAIN_W'(1)));

   // R6
   clamp_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_vld && loud && gain_o > cfg_gain_min) |=>
      ((gain_o == $past(gain_o) - GAIN_W'(1)) && state_o == 2'd3));

   // R5
   rise_in_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (gain_o > $past(gain_o)) |-> (state_o == 2'd2));
endmodule

bind agc_level_ctrl agc_level_ctrl_chk #(.SAMPLE_W(SAMPLE_W), .GAIN_W(GAIN_W)) i_chk (
   .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_data(smp_data),
   .cfg_gain_max(cfg_gain_max), .cfg_gain_min(cfg_gain_min),
   .cfg_limit_mode(cfg_limit_mode), .gain_o(gain_o), .state_o(state_o), .env_o(env_o)
);

// File: tb/test_agc_level_ctrl.sv
`timescale 1ns/1ps
module test_agc_level_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        smp_vld = 1'b0;
   logic [15:0] smp_data = '0;
   logic [14:0] cfg_target = 15'd8000;
   logic [5:0]  cfg_gain_max = 6'd40;
   logic [5:0]  cfg_gain_min = 6'd8;
   logic [3:0]  cfg_atk_rate = 4'd2;
   logic [3:0]  cfg_rel_rate = 4'd3;
   logic        cfg_limit_mode = 1'b0;
   logic [5:0]  gain_o;
   logic [1:0]  state_o;
   logic [14:0] env_o;

   agc_level_ctrl i_agc_level_ctrl (
      .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_data(smp_data),
      .cfg_target(cfg_target), .cfg_gain_max(cfg_gain_max), .cfg_gain_min(cfg_gain_min),
      .cfg_atk_rate(cfg_atk_rate), .cfg_rel_rate(cfg_rel_rate), .cfg_limit_mode(cfg_limit_mode),
      .gain_o(gain_o), .state_o(state_o), .env_o(env_o)
   );

   always #5 clk = ~clk;

   typedef struct { int gain; int st; int env; bit lim; } exp_t;
   exp_t q[$];

   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;

   // reference model state
   int m_env = 0, m_st = 0, m_gain = 32, m_cnt = 0, m_cap = 32;

   task automatic check(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic drive(input int s);
      int mag, drop, env_n, lo, st_n, ceil_v, iv, ce;
      bit step;
      exp_t e;
      @(negedge clk);
      if (s < 0) mag = (s == -32768) ? 32767 : -s; else mag = s;
      drop = m_env >> 4;
      if (drop == 0 && m_env != 0) drop = 1;
      env_n = (mag > m_env) ? mag : m_env - drop;
      lo = int'(cfg_target) - (int'(cfg_target) >> 3) - (int'(cfg_target) >> 5);
      if (mag > 28672)                 st_n = 3;
      else if (env_n > int'(cfg_target)) st_n = 1;
      else if (env_n < lo)             st_n = 2;
      else if (m_st == 1)              st_n = 1;
      else                             st_n = 0;
      ceil_v = cfg_limit_mode ? m_cap : int'(cfg_gain_max);
      iv = 1 << ((st_n == 1) ? int'(cfg_atk_rate) : int'(cfg_rel_rate));
      if (cfg_limit_mode) begin
         iv = iv >> 2;
         if (iv == 0) iv = 1;
      end
      if (st_n == 3) iv = 1;
      ce = (st_n == m_st) ? m_cnt : 0;
      step = (st_n != 0) && (ce == iv - 1);
      if (step) begin
         if ((st_n == 1 || st_n == 3) && m_gain > int'(cfg_gain_min)) m_gain--;
         else if (st_n == 2 && m_gain < ceil_v) m_gain++;
      end
      m_cnt = (st_n == 0 || step) ? 0 : ce + 1;
      m_st  = st_n;
      m_env = env_n;
      e.gain = m_gain; e.st = m_st; e.env = m_env; e.lim = cfg_limit_mode;
      q.push_back(e);
      smp_data = s[15:0];
      smp_vld  = 1'b1;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         smp_vld  = 1'b0;
         smp_data = 16'h7530;   // loud garbage that must be ignored
      end
   endtask

   task automatic set_lim(input bit v);
      @(negedge clk);
      smp_vld = 1'b0;
      if (v && !cfg_limit_mode) m_cap = m_gain;
      cfg_limit_mode = v;
      idle(2);
   endtask

   task automatic burst(input int s, input int n);
      for (int i = 0; i < n; i++) drive(s);
      idle(1);
   endtask

   // monitor: pops expected results after each accepted sample
   initial begin
      forever begin
         @(posedge clk);
         if (smp_vld && rst_n) begin
            exp_t e;
            string gt;
            @(negedge clk);
            e = q.pop_front();
            case (e.st)
               1:       gt = e.lim ? "R9 attack pace" : "R3 attack";
               2:       gt = e.lim ? "R9 release pace" : "R5 release";
               3:       gt = "R6 clamp";
               default: gt = "R4 hold";
            endcase
            check(gt, int'(gain_o), e.gain);
            check("R4 phase", int'(state_o), e.st);
            check("R2 envelope", int'(env_o), e.env);
         end
      end
   end

   initial begin
      #2_000_000;
      if (!done) begin
         done = 1;
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      int env_keep;
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1 gain", int'(gain_o), 32);
      check("R1 phase", int'(state_o), 0);
      check("R1 envelope", int'(env_o), 0);
      rst_n = 1'b1;
      idle(2);

      // R11 first attack step on the 4th sample
      burst(12000, 3);
      check("R11 no step yet", int'(gain_o), 32);
      check("R3 phase attack", int'(state_o), 1);
      burst(12000, 1);
      check("R11 first step", int'(gain_o), 31);
      burst(12000, 36);
      check("R3 ten steps", int'(gain_o), 22);

      // R10 idle cycles with loud data ignored
      env_keep = int'(env_o);
      idle(10);
      check("R10 gain", int'(gain_o), 22);
      check("R10 envelope", int'(env_o), env_keep);
      check("R10 phase", int'(state_o), 1);

      // R4 hysteresis keeps attacking, R7 floor
      burst(7600, 60);
      check("R7 floor", int'(gain_o), 8);
      check("R4 attack kept", int'(state_o), 1);
      check("R4 under target", int'(env_o < 15'd8000), 1);

      // R5 release up to R7 ceiling
      burst(1000, 400);
      check("R7 ceiling", int'(gain_o), 40);
      check("R5 phase release", int'(state_o), 2);

      // R4 band from release gives hold
      burst(7500, 20);
      check("R4 hold phase", int'(state_o), 0);
      check("R4 hold gain", int'(gain_o), 40);

      // R6 clamp ignores slow attack setting
      cfg_atk_rate = 4'd5;
      burst(30000, 5);
      check("R6 clamp gain", int'(gain_o), 35);
      check("R6 clamp phase", int'(state_o), 3);
      burst(-32768, 1);
      check("R2 saturated magnitude", int'(env_o), 32767);
      check("R6 clamp negative", int'(gain_o), 34);
      cfg_atk_rate = 4'd2;

      // R8 limiter ceiling frozen at 34 though max raised
      set_lim(1'b1);
      cfg_gain_max = 6'd60;
      burst(30000, 4);
      check("R6 clamp in limiter", int'(gain_o), 30);
      burst(1000, 300);
      check("R8 frozen ceiling", int'(gain_o), 34);

      // back to normal mode
      set_lim(1'b0);
      cfg_gain_max = 6'd40;
      burst(1000, 100);
      check("R7 normal ceiling", int'(gain_o), 40);

      idle(3);
      check("R4 queue drained", q.size(), 0);
      if (!done) begin
         done = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule